// File: doc/BRIEF.md
# Parallel Poll Answer Unit

This unit sits beside an IEEE-488 style bus interface and answers the parallel poll that the controller in charge runs. The controller starts a poll by asserting ATN and EOI together. While both stay asserted, the unit may pull one data line to report a single status bit. It pulls that line only if the local device has a service request pending. The device's configuration picks which of the eight data lines carries the answer, and a sense input sets the answer's value. A true answer pulls the line. A false answer leaves the line released, because the bus is open-collector and every device that does not pull a line leaves it released.

All five kinds of input (ATN, EOI, the local service-request flag, the sense bit and the line select) pass through the same synchroniser chain before any decision is made, so every input has the same latency. The output is a registered vector of pull enables, one per data line. A 1 means "pull this line to its asserted level" and a 0 means "leave it released". The unit never drives a line high. Bus commands that set up the poll, the transceivers and electrical timing are handled elsewhere.

Top module: `gpib_ppr_responder`

## Requirements
- R1: While `rst_n` is low, all bits of `dio_pull` are 0, starting at once when reset asserts. After reset is released they stay 0 until a poll answer is due.
- R2: The unit treats a poll as in progress only when `atn` and `eoi` are both 1. If only one of them is 1, or neither is, `dio_pull` is all zeros.
- R3: When `srq_pending` is 0, `dio_pull` is all zeros, even during a poll.
- R4: At most one bit of `dio_pull` is 1 at any time. The output is a pull enable only, and 0 means the line is released.
- R5: When an answer is due, the bit of `dio_pull` that is set is bit `line_sel`. Bit 0 is DIO1 and bit 7 is DIO8, so a select value of k pulls line DIO(k+1).
- R6: `sense` = 1 makes the answer true, so the selected line is pulled. `sense` = 0 makes the answer false, so every line stays released.
- R7: A change on any input shows at `dio_pull` on the third rising clock edge after the change. The path is two synchroniser stages and then the output register. The value after the first and second edges is still the old one.
- R8: When `atn` or `eoi` drops during an answer, the pull is released on the very next edge after the synchronised poll condition falls. That is the third edge after the bus change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| atn | input | 1 | Bus attention line, 1 = asserted |
| eoi | input | 1 | Bus end-or-identify line, 1 = asserted |
| srq_pending | input | 1 | Local device has a service request pending |
| line_sel | input | 3 | Data line that carries the answer (0 = DIO1, 7 = DIO8) |
| sense | input | 1 | Answer value: 1 pulls the selected line, 0 leaves it released |
| dio_pull | output | 8 | Pull enables for DIO1..DIO8, 1 = pull line to asserted level |

## Verification
The bench builds the unit with its defaults: eight data lines and two synchroniser stages. With those values the whole input space is only 128 combinations of ATN, EOI, service request, sense and line select, so the bench walks all of them. For each combination it compares the output both on the cycle before the new value must appear and on the cycle it must appear. Walking the combinations back to back also produces every rise and release of the poll condition while an answer is being given. Separate runs cover a reset that arrives while a line is pulled and the refill of the synchroniser chain after reset.

// File: rtl/gpib_ppr_pkg.sv
package gpib_ppr_pkg;

  // Default number of bus data lines served by the unit
  localparam int unsigned DIO_LINES = 8;

  // Control inputs after synchronisation; atn sits in the LSB
  typedef struct packed {
    logic sense;
    logic srq;
    logic eoi;
    logic atn;
  } ppr_ctrl_t;

  localparam int unsigned CTRL_W = $bits(ppr_ctrl_t);

  // Poll condition: attention and end-or-identify asserted together
  function automatic logic poll_cond(input ppr_ctrl_t c);
    return c.atn & c.eoi;
  endfunction

  // Whether a true answer must be placed on the bus this cycle
  function automatic logic answer_due(input ppr_ctrl_t c);
    return poll_cond(c) & c.srq & c.sense;
  endfunction

endpackage

// File: rtl/gpib_ppr_sync.sv
module gpib_ppr_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

  initial begin
    // R7
    stages_min_chk: assert (STAGES >= 1);
  end

endmodule

// File: rtl/gpib_ppr_poll_det.sv
module gpib_ppr_poll_det
  import gpib_ppr_pkg::*;
(
  input  ppr_ctrl_t ctrl_s,
  output logic      poll_now,
  output logic      answer_now
);

  always_comb begin
    poll_now   = poll_cond(ctrl_s);
    answer_now = answer_due(ctrl_s);
  end

endmodule

// File: rtl/gpib_ppr_line_drv.sv
module gpib_ppr_line_drv #(
  parameter int unsigned LINES = 8,
  localparam int unsigned SEL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             answer_now,
  input  logic [SEL_W-1:0] sel,
  output logic [LINES-1:0] pull
);

  logic [LINES-1:0] line_hit;
  logic [LINES-1:0] pull_q;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign line_hit[g] = answer_now && (sel == SEL_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pull_q <= '0;
    else        pull_q <= line_hit;
  end

  assign pull = pull_q;

  // R4
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pull_q));

  // R5
  sel_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    answer_now |=> pull_q[$past(sel)]);

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !answer_now |=> (pull_q == '0));

endmodule

// File: rtl/gpib_ppr_responder.sv
module gpib_ppr_responder
  import gpib_ppr_pkg::*;
#(
  parameter int unsigned LINES       = DIO_LINES,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SEL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             atn,
  input  logic             eoi,
  input  logic             srq_pending,
  input  logic [SEL_W-1:0] line_sel,
  input  logic             sense,
  output logic [LINES-1:0] dio_pull
);

  localparam int unsigned SYNC_W = CTRL_W + SEL_W;

  logic [SYNC_W-1:0] raw_vec;
  logic [SYNC_W-1:0] synced_vec;
  ppr_ctrl_t         ctrl_s;
  logic [SEL_W-1:0]  sel_s;
  logic              poll_now;
  logic              answer_now;

  assign raw_vec = {line_sel, sense, srq_pending, eoi, atn};

  gpib_ppr_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_vec),
    .q     (synced_vec)
  );

  assign ctrl_s = ppr_ctrl_t'(synced_vec[CTRL_W-1:0]);
  assign sel_s  = synced_vec[SYNC_W-1:CTRL_W];

  gpib_ppr_poll_det u_poll (
    .ctrl_s     (ctrl_s),
    .poll_now   (poll_now),
    .answer_now (answer_now)
  );

  gpib_ppr_line_drv #(
    .LINES (LINES)
  ) u_drv (
    .clk        (clk),
    .rst_n      (rst_n),
    .answer_now (answer_now),
    .sel        (sel_s),
    .pull       (dio_pull)
  );

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (dio_pull == '0);
    end
  end

  // R2
  no_poll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_now |=> (dio_pull == '0));

  // R3
  no_srq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_s.srq |=> (dio_pull == '0));

  // R6
  false_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_s.sense |=> (dio_pull == '0));

  // R8
  poll_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(poll_now) |=> (dio_pull == '0));

endmodule

// File: tb/test_gpib_ppr_responder.sv
module test_gpib_ppr_responder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       atn = 1'b0;
  logic       eoi = 1'b0;
  logic       srq_pending = 1'b0;
  logic [2:0] line_sel = 3'd0;
  logic       sense = 1'b0;
  logic [7:0] dio_pull;

  int vectors = 0;
  int fails   = 0;

  always #5 clk = ~clk;

  gpib_ppr_responder i_gpib_ppr_responder (
    .clk         (clk),
    .rst_n       (rst_n),
    .atn         (atn),
    .eoi         (eoi),
    .srq_pending (srq_pending),
    .line_sel    (line_sel),
    .sense       (sense),
    .dio_pull    (dio_pull)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: dio_pull got %b expected %b", tag, got, exp);
    end
  endtask

  // Expected pull vector, rebuilt bit by bit from the requirements
  function automatic logic [7:0] model(input logic a, input logic e, input logic s,
                                       input logic sn, input logic [2:0] k);
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = a && e && s && sn && (int'(k) == i);
    return v;
  endfunction

  function automatic string pick_tag(input logic a, input logic e, input logic s,
                                     input logic sn);
    if (!(a && e)) return "R2";
    if (!s)        return "R3";
    if (!sn)       return "R6";
    return "R5";
  endfunction

  // Apply a vector, then check old value after two edges and new after three
  task automatic apply(input logic a, input logic e, input logic s, input logic sn,
                       input logic [2:0] k, input logic [7:0] prev_exp);
    logic [7:0] nxt;
    nxt = model(a, e, s, sn, k);
    @(negedge clk);
    atn = a; eoi = e; srq_pending = s; sense = sn; line_sel = k;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7 hold", dio_pull, prev_exp);
    @(posedge clk);
    @(negedge clk);
    check(pick_tag(a, e, s, sn), dio_pull, nxt);
    vectors++;
    if ($countones(dio_pull) > 1) begin
      fails++;
      $display("FAIL R4: dio_pull got %b expected at most one bit set", dio_pull);
    end
  endtask

  initial begin
    logic [7:0] prev;
    // R1: quiet during reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", dio_pull, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 after release", dio_pull, 8'h00);

    // Exhaustive sweep of all 128 input combinations
    prev = 8'h00;
    for (int k = 0; k < 8; k++) begin
      for (int code = 0; code < 16; code++) begin
        logic a, e, s, sn;
        a = code[0]; e = code[1]; s = code[2]; sn = code[3];
        apply(a, e, s, sn, 3'(k), prev);
        prev = model(a, e, s, sn, 3'(k));
      end
    end

    // R8: drop of eoi alone while answering
    apply(1'b1, 1'b1, 1'b1, 1'b1, 3'd6, prev);
    apply(1'b1, 1'b0, 1'b1, 1'b1, 3'd6, 8'h40);
    // R8: drop of atn alone while answering
    apply(1'b1, 1'b1, 1'b1, 1'b1, 3'd1, 8'h00);
    apply(1'b0, 1'b1, 1'b1, 1'b1, 3'd1, 8'h02);

    // R1: reset arriving while a line is pulled
    apply(1'b1, 1'b1, 1'b1, 1'b1, 3'd5, 8'h00);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", dio_pull, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7 refill hold", dio_pull, 8'h00);
    @(posedge clk);
    @(negedge clk);
    check("R7 refill", dio_pull, 8'h20);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule